// File: doc/BRIEF.md
# Cascadable bidirectional LCD common scanner

This block is the logic half of a row (common) driver for a passive dot-matrix LCD. A chain of scan stages, one per common row, moves a single "active row" marker along the panel on each falling edge of the scan clock. A direction input sets which way the marker travels. Each stage turns its stored bit, the frame polarity and an active-low blanking input into a 2-bit code. The code selects one of four bias levels for that row's analog driver, which lies outside this block.

Both ends of the chain are bidirectional pins, each split here into an input, an output and an output enable. The end where data enters is an input. The opposite end drives out the last stage's bit, so that several devices can be chained and scan a taller panel. When the direction flips, the two ends swap roles. That lets the same wiring serve a panel mounted either way up.

Top module: `lcd_com_scanner`

## Requirements
- R1: The chain has STAGES stages (default 64). A synchronous active-high reset, taken on the falling scan-clock edge, clears every stage to 0.
- R2: With `dir_left` low, each falling scan-clock edge loads stage 0 from `lo_end_in`. Every stage i>0 takes the old value of stage i-1.
- R3: With `dir_left` high, each falling scan-clock edge loads stage STAGES-1 from `hi_end_in`. Every stage i<STAGES-1 takes the old value of stage i+1.
- R4: Exactly one end enable is high. `hi_end_oe` is high when `dir_left` is low, and `lo_end_oe` is high when `dir_left` is high. An end whose enable is low drives 0 on its output.
- R5: The enabled end output carries the last stage in the shift direction: stage STAGES-1 for a right shift, stage 0 for a left shift. It changes only after a falling scan-clock edge.
- R6: With `blank_n` high, stage i drives `lvl_code[2i+1:2i]` from its bit and `frame_pol` (codes: 00=V1, 01=V2, 10=V5, 11=VEE). The mapping is: frame 0 and bit 0 gives 01, frame 0 and bit 1 gives 11, frame 1 and bit 0 gives 10, frame 1 and bit 1 gives 00.
- R7: With `blank_n` low, every stage drives code 00, whatever the frame polarity and the stored bits are.
- R8: Wiring one device's enabled end output to the next device's entry input forms one chain of 2*STAGES stages, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Scan clock; state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_left | input | 1 | 0: shift toward the high end; 1: shift toward the low end |
| blank_n | input | 1 | Active-low display blanking |
| frame_pol | input | 1 | Frame alternation polarity |
| lo_end_in | input | 1 | Low-end pin, input side |
| lo_end_out | output | 1 | Low-end pin, output side |
| lo_end_oe | output | 1 | Low-end pin, output enable |
| hi_end_in | input | 1 | High-end pin, input side |
| hi_end_out | output | 1 | High-end pin, output side |
| hi_end_oe | output | 1 | High-end pin, output enable |
| lvl_code | output | 2*STAGES | Bias-level code, two bits per stage, stage 0 lowest |

## Verification
The hardest case to reach is the handoff between two chained devices. The far stage of the first device has to emerge on its cascade output, and on the same edge the second device has to capture it, with no bubble or duplicate. The bench gets there by chaining two instances and injecting a single marker. It then clocks the marker across all 128 positions in each direction, comparing every stage code and both cascade outputs after every edge. A separate sweep parks the marker in one stage and walks frame polarity and blanking through all four combinations.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;
   localparam int LVL_W = 2;

   typedef enum logic [LVL_W-1:0] {
      LVL_V1  = 2'b00,
      LVL_V2  = 2'b01,
      LVL_V5  = 2'b10,
      LVL_VEE = 2'b11
   } bias_lvl_t;
endpackage

// File: rtl/lcd_scan_shreg.sv
module lcd_scan_shreg #(
   parameter int STAGES = 64
) (
   input  logic              scan_clk,
   input  logic              rst,
   input  logic              dir_left,
   input  logic              lo_in,
   input  logic              hi_in,
   output logic [STAGES-1:0] stg
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] nxt;

   // each stage picks its neighbour; end stages pick the pin instead
   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic from_low, from_high;
      if (i == 0) begin : g_lo_edge
         assign from_low = lo_in;
      end else begin : g_lo_mid
         assign from_low = stg[i-1];
      end
      if (i == LAST) begin : g_hi_edge
         assign from_high = hi_in;
      end else begin : g_hi_mid
         assign from_high = stg[i+1];
      end
      assign nxt[i] = dir_left ? from_high : from_low;
   end

   always_ff @(negedge scan_clk) begin
      if (rst) stg <= '0;
      else     stg <= nxt;
   end
endmodule

// File: rtl/lcd_end_port.sv
module lcd_end_port #(
   parameter bit DRIVE_ON_LEFT = 1'b0
) (
   input  logic dir_left,
   input  logic last_bit,
   output logic pin_out,
   output logic pin_oe
);
   if (DRIVE_ON_LEFT) begin : g_low_end
      assign pin_oe = dir_left;
   end else begin : g_high_end
      assign pin_oe = ~dir_left;
   end
   assign pin_out = pin_oe & last_bit;
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
   import lcd_com_pkg::*;
(
   input  logic             row_bit,
   input  logic             frame_pol,
   input  logic             blank_n,
   output logic [LVL_W-1:0] code
);
   bias_lvl_t lvl;

   always_comb begin
      unique case ({blank_n, frame_pol, row_bit})
         3'b100:  lvl = LVL_V2;
         3'b101:  lvl = LVL_VEE;
         3'b110:  lvl = LVL_V5;
         3'b111:  lvl = LVL_V1;
         default: lvl = LVL_V1;
      endcase
   end
   assign code = lvl;
endmodule

// File: rtl/lcd_com_scanner.sv
module lcd_com_scanner
   import lcd_com_pkg::*;
#(
   parameter int STAGES = 64
) (
   input  logic                    scan_clk,
   input  logic                    rst,
   input  logic                    dir_left,
   input  logic                    blank_n,
   input  logic                    frame_pol,
   input  logic                    lo_end_in,
   output logic                    lo_end_out,
   output logic                    lo_end_oe,
   input  logic                    hi_end_in,
   output logic                    hi_end_out,
   output logic                    hi_end_oe,
   output logic [LVL_W*STAGES-1:0] lvl_code
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("lcd_com_scanner: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg;

   lcd_scan_shreg #(.STAGES(STAGES)) u_chain (
      .scan_clk (scan_clk),
      .rst      (rst),
      .dir_left (dir_left),
      .lo_in    (lo_end_in),
      .hi_in    (hi_end_in),
      .stg      (stg)
   );

   lcd_end_port #(.DRIVE_ON_LEFT(1'b1)) u_lo_end (
      .dir_left (dir_left),
      .last_bit (stg[0]),
      .pin_out  (lo_end_out),
      .pin_oe   (lo_end_oe)
   );

   lcd_end_port #(.DRIVE_ON_LEFT(1'b0)) u_hi_end (
      .dir_left (dir_left),
      .last_bit (stg[LAST]),
      .pin_out  (hi_end_out),
      .pin_oe   (hi_end_oe)
   );

   for (genvar i = 0; i < STAGES; i++) begin : g_enc
      lcd_level_enc u_enc (
         .row_bit   (stg[i]),
         .frame_pol (frame_pol),
         .blank_n   (blank_n),
         .code      (lvl_code[LVL_W*i +: LVL_W])
      );
   end
endmodule

// File: rtl/lcd_com_scanner_chk.sv
module lcd_com_scanner_chk #(
   parameter int STAGES = 64
) (
   input logic                    scan_clk,
   input logic                    rst,
   input logic                    dir_left,
   input logic                    blank_n,
   input logic                    lo_end_in,
   input logic                    hi_end_in,
   input logic                    lo_end_out,
   input logic                    lo_end_oe,
   input logic                    hi_end_out,
   input logic                    hi_end_oe,
   input logic [STAGES-1:0]       stg,
   input logic [2*STAGES-1:0]     lvl_code
);
   // R1
   reset_clears_chk: assert property (@(negedge scan_clk)
      rst |=> stg == '0);

   // R2
   right_entry_chk: assert property (@(negedge scan_clk) disable iff (rst)
      !dir_left |=> stg[0] == $past(lo_end_in));

   // R2
   right_body_chk: assert property (@(negedge scan_clk) disable iff (rst)
      !dir_left |=> stg[STAGES-1:1] == $past(stg[STAGES-2:0]));

   // R3
   left_entry_chk: assert property (@(negedge scan_clk) disable iff (rst)
      dir_left |=> stg[STAGES-1] == $past(hi_end_in));

   // R3
   left_body_chk: assert property (@(negedge scan_clk) disable iff (rst)
      dir_left |=> stg[STAGES-2:0] == $past(stg[STAGES-1:1]));

   // R4
   one_end_driven_chk: assert property (@(negedge scan_clk) disable iff (rst)
      $countones({lo_end_oe, hi_end_oe}) == 1 && hi_end_oe == !dir_left);

   // R4
   idle_end_low_chk: assert property (@(negedge scan_clk) disable iff (rst)
      (!lo_end_oe |-> !lo_end_out) and (!hi_end_oe |-> !hi_end_out));

   // R5
   cascade_follows_last_chk: assert property (@(negedge scan_clk) disable iff (rst)
      (hi_end_oe |-> hi_end_out == stg[STAGES-1]) and (lo_end_oe |-> lo_end_out == stg[0]));

   // R7
   blank_forces_v1_chk: assert property (@(negedge scan_clk) disable iff (rst)
      !blank_n |-> lvl_code == '0);
endmodule

bind lcd_com_scanner lcd_com_scanner_chk #(.STAGES(STAGES)) u_chk (
   .scan_clk   (scan_clk),
   .rst        (rst),
   .dir_left   (dir_left),
   .blank_n    (blank_n),
   .lo_end_in  (lo_end_in),
   .hi_end_in  (hi_end_in),
   .lo_end_out (lo_end_out),
   .lo_end_oe  (lo_end_oe),
   .hi_end_out (hi_end_out),
   .hi_end_oe  (hi_end_oe),
   .stg        (stg),
   .lvl_code   (lvl_code)
);

// File: tb/lcd_com_scanner_test.sv
module lcd_com_scanner_test;
   localparam int N      = 64;
   localparam int CLK_NS = 20;

   logic clk = 1'b1;
   always #(CLK_NS/2) clk = ~clk;

   logic rst = 1'b1, dir_left = 1'b0, blank_n = 1'b1, frame_pol = 1'b0, feed = 1'b0;
   logic a_lo_out, a_lo_oe, a_hi_out, a_hi_oe;
   logic b_lo_out, b_lo_oe, b_hi_out, b_hi_oe;
   logic [2*N-1:0] a_code, b_code;

   int errors = 0;
   int checks = 0;

   // first device: entry at its low end for right shifts
   lcd_com_scanner #(.STAGES(N)) uut (
      .scan_clk(clk), .rst(rst), .dir_left(dir_left), .blank_n(blank_n),
      .frame_pol(frame_pol),
      .lo_end_in(feed), .lo_end_out(a_lo_out), .lo_end_oe(a_lo_oe),
      .hi_end_in(b_lo_out), .hi_end_out(a_hi_out), .hi_end_oe(a_hi_oe),
      .lvl_code(a_code)
   );

   // second device: entry at its high end for left shifts
   lcd_com_scanner #(.STAGES(N)) uut_next (
      .scan_clk(clk), .rst(rst), .dir_left(dir_left), .blank_n(blank_n),
      .frame_pol(frame_pol),
      .lo_end_in(a_hi_out), .lo_end_out(b_lo_out), .lo_end_oe(b_lo_oe),
      .hi_end_in(feed), .hi_end_out(b_hi_out), .hi_end_oe(b_hi_oe),
      .lvl_code(b_code)
   );

   // expected code vector for one device; pos < 0 means no marker
   function automatic logic [2*N-1:0] exp_codes(int pos, logic fr, logic bn);
      logic [2*N-1:0] v;
      for (int i = 0; i < N; i++) begin
         logic b;
         logic [1:0] c;
         b = (i == pos);
         if (!bn)     c = 2'b00;
         else if (fr) c = b ? 2'b00 : 2'b10;
         else         c = b ? 2'b11 : 2'b01;
         v[2*i +: 2] = c;
      end
      return v;
   endfunction

   task automatic check(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one falling edge, then settle to just after the next rising edge
   task automatic tick();
      @(negedge clk);
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick();
      tick();
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_NS * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(posedge clk);
      #1;
      do_reset();
      // R1: reset state
      check("R1 reset A", a_code, exp_codes(-1, 1'b0, 1'b1));
      check("R1 reset B", b_code, exp_codes(-1, 1'b0, 1'b1));
      check("R4 idle ends", {126'd0, a_lo_out, b_lo_out}, '0);
      check("R4 right oe", {124'd0, a_lo_oe, a_hi_oe, b_lo_oe, b_hi_oe}, 128'b0101);

      // R2 R5 R8: marker travels right through both devices
      dir_left = 1'b0;
      feed = 1'b1;
      tick();
      feed = 1'b0;
      for (int k = 1; k <= 2*N; k++) begin
         if (k > 1) tick();
         check("R2 right A", a_code, exp_codes(k <= N ? k-1 : -1, 1'b0, 1'b1));
         check("R8 right B", b_code, exp_codes(k > N ? k-N-1 : -1, 1'b0, 1'b1));
         check("R5 right cascade", {126'd0, a_hi_out, b_hi_out},
               {126'd0, k == N, k == 2*N});
      end
      tick();
      check("R2 right drained", {a_code, b_code}, {exp_codes(-1, 1'b0, 1'b1), exp_codes(-1, 1'b0, 1'b1)});

      // R3 R4 R5 R8: marker travels left through both devices
      dir_left = 1'b1;
      #1;
      check("R4 left oe", {124'd0, a_lo_oe, a_hi_oe, b_lo_oe, b_hi_oe}, 128'b1010);
      feed = 1'b1;
      tick();
      feed = 1'b0;
      for (int k = 1; k <= 2*N; k++) begin
         if (k > 1) tick();
         check("R3 left B", b_code, exp_codes(k <= N ? N-k : -1, 1'b0, 1'b1));
         check("R8 left A", a_code, exp_codes(k > N ? 2*N-k : -1, 1'b0, 1'b1));
         check("R5 left cascade", {126'd0, b_lo_out, a_lo_out},
               {126'd0, k == N, k == 2*N});
         check("R4 left idle ends", {126'd0, a_hi_out, b_hi_out}, '0);
      end

      // R6 R7: park a marker at stage 5 of the first device, sweep frame and blanking
      do_reset();
      dir_left = 1'b0;
      feed = 1'b1;
      tick();
      feed = 1'b0;
      for (int k = 0; k < 5; k++) tick();
      for (int m = 0; m < 4; m++) begin
         frame_pol = m[0];
         blank_n   = m[1];
         #2;
         check(blank_n ? "R6 levels" : "R7 blank", a_code, exp_codes(5, frame_pol, blank_n));
         check(blank_n ? "R6 row code" : "R7 row code", {126'd0, a_code[11:10]},
               {126'd0, exp_codes(5, frame_pol, blank_n)} >> 10 & 128'd3);
      end
      blank_n = 1'b0;
      tick();
      check("R7 blank while shifting", {a_code, b_code}, '0);
      blank_n = 1'b1;
      frame_pol = 1'b0;

      // R1: reset clears a loaded chain
      do_reset();
      check("R1 reset clears", {a_code, b_code}, {exp_codes(-1, 1'b0, 1'b1), exp_codes(-1, 1'b0, 1'b1)});

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule